// File: doc/BRIEF.md
# Lockable Sixteen-Pin I/O Port Register Block

This block holds the register state of one sixteen-pin general-purpose I/O port and turns it into per-pin drive controls for a pad wrapper. Software reaches it over a word-wide register bus with one write strobe, a word address and write data. Writes take effect at the clock edge. Read data is combinational from the addressed register. The bus has no back-pressure: every write is accepted in the cycle it is presented, and no stream interface exists, so every pin is a plain control or status signal.

Each pin carries a direction/function mode, a push-pull or open-drain flag, a speed grade, a pull selection and a four-bit alternate-function selector. The output data word can be written directly. It can also be changed atomically through a set/clear word and a clear-only word, so a pin never needs a read-modify-write. Pad inputs pass through a two-flop synchronizer before software can read them.

A key sequence of three writes to the lock word freezes the configuration of a chosen set of pins until the next reset. Output data, set/clear and clear-only writes keep working on locked pins.

Top module: `lockable_io_port`

Register word addresses: 0 mode, 1 output type, 2 speed, 3 pull, 4 input data (read-only), 5 output data, 6 set/clear (write-only, reads 0), 7 clear-only (write-only, reads 0), 8 alternate function pins 0–7, 9 alternate function pins 8–15, 10 lock. Unmapped addresses read 0 and ignore writes.

## Requirements
- R1: On a cycle with rst_n low, every register returns to 0 at the next clock edge: all modes input, push-pull, speed 0, pull 0, alternate function 0, output data 0, lock mask 0 and key bit 0. No pad is driven.
- R2: Mode, speed and pull words hold one 2-bit field per pin at bits 2n+1:2n. A write replaces the fields of unlocked pins, and the fields appear on pad_mode, pad_speed and pad_pull. Mode codes are 0 input, 1 general output, 2 alternate function and 3 analog.
- R3: Output-type bit n selects push-pull (0) or open-drain (1). A pin in mode 1 drives its output data bit, and a pin in mode 2 drives alt_do[n]. pad_do carries that value. pad_oe is 1 unless the pin is open-drain and the value is 1. Pins in modes 0 and 3 have pad_oe and pad_do at 0.
- R4: The 4-bit alternate-function selector of pin n sits in word 8 at bits 4n+3:4n for pins 0–7, and in word 9 at bits 4(n−8)+3:4(n−8) for pins 8–15. pad_af_sel carries pin n at bits 4n+3:4n.
- R5: A write to the set/clear word sets output bit n where write bit n is 1, and clears output bit n where write bit n+16 is 1. When both bits are 1, set wins. Other bits are unchanged.
- R6: A write to the clear-only word clears output bit n where write bit n is 1 and leaves the other bits unchanged.
- R7: Writing the output data word replaces all sixteen bits and reads back the same value, so writing the inverted value toggles pins.
- R8: The input data word shows pad_in through two flops: a level applied before clock edge k reads back after edge k+1.
- R9: Three lock-word writes are required: key bit 16 = 1 with mask M, then key 0 with M, then key 1 with M. After the third write, the lock word reads key bit 16 = 1 and bits 15:0 = M.
- R10: A lock-word write with a different mask or the wrong key breaks the sequence. A key-1 write starts a new sequence, and a key-0 write returns to idle. No lock takes effect, and the lock word keeps reading 0. Writes to other words do not disturb the sequence.
- R11: For a locked pin, its fields in the mode, output-type, speed, pull and both alternate-function words ignore writes. Unlocked pins in the same word still update.
- R12: Once the lock is set, further lock-word writes are ignored and the mask and key bit hold until reset. Reset clears them.
- R13: Output data, set/clear and clear-only writes act on locked pins exactly as on unlocked pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| pad_in | input | 16 | Raw pad input levels |
| alt_do | input | 16 | Per-pin output value from the selected alternate function |
| pad_mode | output | 32 | Per-pin mode, 2 bits each |
| pad_speed | output | 32 | Per-pin speed grade, 2 bits each |
| pad_pull | output | 32 | Per-pin pull selection, 2 bits each |
| pad_af_sel | output | 64 | Per-pin alternate-function selector, 4 bits each |
| pad_do | output | 16 | Per-pin drive value |
| pad_oe | output | 16 | Per-pin drive enable |

## Verification
A wrong lock state shows at the ports either as a frozen pad_mode, pad_speed, pad_pull or pad_af_sel field that should have followed a write, or as a field that moved when it should not have. In both cases it appears one cycle after the write. The lock word's key bit and mask readback expose a broken key sequence in the cycle after its third write. A wrong output data bit shows on pad_do/pad_oe of any pin in output mode one cycle after the write. A wrong synchronizer depth shifts the input data readback by a cycle. Comparing every output against a behavioural model on every clock catches each of these at its first visible cycle.

// File: rtl/lkp_pkg.sv
`timescale 1ns/1ps
package lkp_pkg;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_ALTFN  = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_ARM1,
    LK_ARM0,
    LK_DONE
  } lock_state_e;

  localparam logic [3:0] RA_MODE   = 4'd0;
  localparam logic [3:0] RA_OTYPE  = 4'd1;
  localparam logic [3:0] RA_SPEED  = 4'd2;
  localparam logic [3:0] RA_PULL   = 4'd3;
  localparam logic [3:0] RA_IN     = 4'd4;
  localparam logic [3:0] RA_OUT    = 4'd5;
  localparam logic [3:0] RA_SETCLR = 4'd6;
  localparam logic [3:0] RA_CLR    = 4'd7;
  localparam logic [3:0] RA_AFLO   = 4'd8;
  localparam logic [3:0] RA_AFHI   = 4'd9;
  localparam logic [3:0] RA_LOCK   = 4'd10;

endpackage

// File: rtl/lkp_cfg_bank.sv
`timescale 1ns/1ps
// One configuration word: NPIN fields of FW bits, each frozen by its lock bit.
module lkp_cfg_bank #(
  parameter int NPIN = 16,
  parameter int FW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NPIN*FW-1:0] wdata,
  input  logic [NPIN-1:0]    lock,
  output logic [NPIN*FW-1:0] q
);

  logic [FW-1:0] fld [NPIN];

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n)
        fld[p] <= '0;
      else if (we && !lock[p])
        fld[p] <= wdata[p*FW +: FW];
    end
    assign q[p*FW +: FW] = fld[p];

    // R11
    frozen_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock[p] |=> $stable(q[p*FW +: FW]));
  end

endmodule

// File: rtl/lkp_lock_seq.sv
`timescale 1ns/1ps
// Three-write key sequence that commits a per-pin freeze mask.
module lkp_lock_seq
  import lkp_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NPIN:0]   wdata,
  output logic [NPIN-1:0] lock_mask,
  output logic            done
);

  lock_state_e     st_q, st_d;
  logic [NPIN-1:0] pend_q, pend_d;
  logic [NPIN-1:0] mask_q, mask_d;
  logic            key;
  logic [NPIN-1:0] msk;
  logic            same;

  assign key  = wdata[NPIN];
  assign msk  = wdata[NPIN-1:0];
  assign same = (msk == pend_q);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    mask_d = mask_q;
    if (we && st_q != LK_DONE) begin
      unique case (st_q)
        LK_ARM1: begin
          if (!key && same)  st_d = LK_ARM0;
          else if (key)      begin st_d = LK_ARM1; pend_d = msk; end
          else               st_d = LK_IDLE;
        end
        LK_ARM0: begin
          if (key && same)   begin st_d = LK_DONE; mask_d = pend_q; end
          else if (key)      begin st_d = LK_ARM1; pend_d = msk; end
          else               st_d = LK_IDLE;
        end
        default: begin
          if (key)           begin st_d = LK_ARM1; pend_d = msk; end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign lock_mask = mask_q;
  assign done      = (st_q == LK_DONE);

  // R12
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R12
  lock_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(lock_mask));

  // R10
  no_lock_before_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || lock_mask == '0));

endmodule

// File: rtl/lkp_out_ctrl.sv
`timescale 1ns/1ps
// Output data word with atomic set/clear paths and the per-pin pad drive.
module lkp_out_ctrl
  import lkp_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_we,
  input  logic [NPIN-1:0]   out_wdata,
  input  logic              setclr_we,
  input  logic [NPIN-1:0]   set_mask,
  input  logic [NPIN-1:0]   sc_clr_mask,
  input  logic              clr_we,
  input  logic [NPIN-1:0]   clr_mask,
  input  logic [2*NPIN-1:0] mode,
  input  logic [NPIN-1:0]   otype,
  input  logic [NPIN-1:0]   alt_do,
  output logic [NPIN-1:0]   out_q,
  output logic [NPIN-1:0]   pad_do,
  output logic [NPIN-1:0]   pad_oe
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_q <= '0;
    else if (out_we)
      out_q <= out_wdata;
    else if (setclr_we)
      out_q <= (out_q & ~sc_clr_mask) | set_mask;
    else if (clr_we)
      out_q <= out_q & ~clr_mask;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_drv
    logic drive;
    logic val;
    always_comb begin
      drive = 1'b0;
      val   = 1'b0;
      if (mode[2*p +: 2] == PM_OUTPUT) begin
        drive = 1'b1;
        val   = out_q[p];
      end else if (mode[2*p +: 2] == PM_ALTFN) begin
        drive = 1'b1;
        val   = alt_do[p];
      end
    end
    assign pad_do[p] = val;
    assign pad_oe[p] = drive && !(otype[p] && val);
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setclr_we |=> ((out_q & $past(set_mask)) == $past(set_mask)));

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((out_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/lkp_in_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for the pad input levels.
module lkp_in_sync #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] q
);

  logic [NPIN-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= pad_in;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/lockable_io_port.sv
`timescale 1ns/1ps
module lockable_io_port
  import lkp_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int AFW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NPIN-1:0]     pad_in,
  input  logic [NPIN-1:0]     alt_do,
  output logic [2*NPIN-1:0]   pad_mode,
  output logic [2*NPIN-1:0]   pad_speed,
  output logic [2*NPIN-1:0]   pad_pull,
  output logic [AFW*NPIN-1:0] pad_af_sel,
  output logic [NPIN-1:0]     pad_do,
  output logic [NPIN-1:0]     pad_oe
);

  localparam int AF_LO = DW / AFW;
  localparam int AF_HI = NPIN - AF_LO;

  logic wr_mode, wr_otype, wr_speed, wr_pull, wr_out, wr_setclr, wr_clr;
  logic wr_aflo, wr_afhi, wr_lock;

  assign wr_mode   = bus_wr_en && (bus_addr == RA_MODE);
  assign wr_otype  = bus_wr_en && (bus_addr == RA_OTYPE);
  assign wr_speed  = bus_wr_en && (bus_addr == RA_SPEED);
  assign wr_pull   = bus_wr_en && (bus_addr == RA_PULL);
  assign wr_out    = bus_wr_en && (bus_addr == RA_OUT);
  assign wr_setclr = bus_wr_en && (bus_addr == RA_SETCLR);
  assign wr_clr    = bus_wr_en && (bus_addr == RA_CLR);
  assign wr_aflo   = bus_wr_en && (bus_addr == RA_AFLO);
  assign wr_afhi   = bus_wr_en && (bus_addr == RA_AFHI);
  assign wr_lock   = bus_wr_en && (bus_addr == RA_LOCK);

  logic [NPIN-1:0]      lock_mask;
  logic                 lock_done;
  logic [2*NPIN-1:0]    mode_q, speed_q, pull_q;
  logic [NPIN-1:0]      otype_q;
  logic [AFW*AF_LO-1:0] aflo_q;
  logic [AFW*AF_HI-1:0] afhi_q;
  logic [NPIN-1:0]      out_q;
  logic [NPIN-1:0]      in_q;

  lkp_lock_seq #(.NPIN(NPIN)) u_lock (
    .clk(clk), .rst_n(rst_n), .we(wr_lock), .wdata(bus_wdata[NPIN:0]),
    .lock_mask(lock_mask), .done(lock_done)
  );

  lkp_cfg_bank #(.NPIN(NPIN), .FW(2)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(wr_mode), .wdata(bus_wdata[2*NPIN-1:0]),
    .lock(lock_mask), .q(mode_q)
  );

  lkp_cfg_bank #(.NPIN(NPIN), .FW(1)) u_otype (
    .clk(clk), .rst_n(rst_n), .we(wr_otype), .wdata(bus_wdata[NPIN-1:0]),
    .lock(lock_mask), .q(otype_q)
  );

  lkp_cfg_bank #(.NPIN(NPIN), .FW(2)) u_speed (
    .clk(clk), .rst_n(rst_n), .we(wr_speed), .wdata(bus_wdata[2*NPIN-1:0]),
    .lock(lock_mask), .q(speed_q)
  );

  lkp_cfg_bank #(.NPIN(NPIN), .FW(2)) u_pull (
    .clk(clk), .rst_n(rst_n), .we(wr_pull), .wdata(bus_wdata[2*NPIN-1:0]),
    .lock(lock_mask), .q(pull_q)
  );

  lkp_cfg_bank #(.NPIN(AF_LO), .FW(AFW)) u_aflo (
    .clk(clk), .rst_n(rst_n), .we(wr_aflo), .wdata(bus_wdata[AFW*AF_LO-1:0]),
    .lock(lock_mask[AF_LO-1:0]), .q(aflo_q)
  );

  lkp_cfg_bank #(.NPIN(AF_HI), .FW(AFW)) u_afhi (
    .clk(clk), .rst_n(rst_n), .we(wr_afhi), .wdata(bus_wdata[AFW*AF_HI-1:0]),
    .lock(lock_mask[NPIN-1:AF_LO]), .q(afhi_q)
  );

  lkp_out_ctrl #(.NPIN(NPIN)) u_out (
    .clk(clk), .rst_n(rst_n),
    .out_we(wr_out), .out_wdata(bus_wdata[NPIN-1:0]),
    .setclr_we(wr_setclr), .set_mask(bus_wdata[NPIN-1:0]),
    .sc_clr_mask(bus_wdata[2*NPIN-1:NPIN]),
    .clr_we(wr_clr), .clr_mask(bus_wdata[NPIN-1:0]),
    .mode(mode_q), .otype(otype_q), .alt_do(alt_do),
    .out_q(out_q), .pad_do(pad_do), .pad_oe(pad_oe)
  );

  lkp_in_sync #(.NPIN(NPIN)) u_in (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .q(in_q)
  );

  assign pad_mode   = mode_q;
  assign pad_speed  = speed_q;
  assign pad_pull   = pull_q;
  assign pad_af_sel = {afhi_q, aflo_q};

  always_comb begin
    unique case (bus_addr)
      RA_MODE:  bus_rdata = DW'(mode_q);
      RA_OTYPE: bus_rdata = DW'(otype_q);
      RA_SPEED: bus_rdata = DW'(speed_q);
      RA_PULL:  bus_rdata = DW'(pull_q);
      RA_IN:    bus_rdata = DW'(in_q);
      RA_OUT:   bus_rdata = DW'(out_q);
      RA_AFLO:  bus_rdata = DW'(aflo_q);
      RA_AFHI:  bus_rdata = DW'(afhi_q);
      RA_LOCK:  bus_rdata = DW'({lock_done, lock_mask});
      default:  bus_rdata = '0;
    endcase
  end

  // R7
  out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> (out_q == $past(bus_wdata[NPIN-1:0])));

endmodule

// File: tb/lockable_io_port_tb.sv
`timescale 1ns/1ps
module lockable_io_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] alt_do = '0;
  logic [31:0] pad_mode, pad_speed, pad_pull;
  logic [63:0] pad_af_sel;
  logic [15:0] pad_do, pad_oe;

  always #4 clk = ~clk;

  lockable_io_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .alt_do(alt_do), .pad_mode(pad_mode), .pad_speed(pad_speed),
    .pad_pull(pad_pull), .pad_af_sel(pad_af_sel), .pad_do(pad_do),
    .pad_oe(pad_oe)
  );

  // behavioural reference state
  logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
  logic [15:0] m_ot, m_out, m_s1, m_s2, m_lock, m_pend;
  logic        m_done;
  int          m_step;
  int          vectors = 0;
  int          fails = 0;
  bit          started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_speed = 0; m_pull = 0; m_aflo = 0; m_afhi = 0;
      m_ot = 0; m_out = 0; m_s1 = 0; m_s2 = 0; m_lock = 0; m_pend = 0;
      m_done = 0; m_step = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (bus_wr_en) begin
        case (bus_addr)
          4'd0: for (int n = 0; n < 16; n++) if (!m_lock[n]) m_mode[2*n +: 2] = bus_wdata[2*n +: 2];
          4'd1: for (int n = 0; n < 16; n++) if (!m_lock[n]) m_ot[n] = bus_wdata[n];
          4'd2: for (int n = 0; n < 16; n++) if (!m_lock[n]) m_speed[2*n +: 2] = bus_wdata[2*n +: 2];
          4'd3: for (int n = 0; n < 16; n++) if (!m_lock[n]) m_pull[2*n +: 2] = bus_wdata[2*n +: 2];
          4'd5: m_out = bus_wdata[15:0];
          4'd6: m_out = (m_out & ~bus_wdata[31:16]) | bus_wdata[15:0];
          4'd7: m_out = m_out & ~bus_wdata[15:0];
          4'd8: for (int n = 0; n < 8; n++) if (!m_lock[n]) m_aflo[4*n +: 4] = bus_wdata[4*n +: 4];
          4'd9: for (int n = 0; n < 8; n++) if (!m_lock[n+8]) m_afhi[4*n +: 4] = bus_wdata[4*n +: 4];
          4'd10: if (!m_done) begin
            if (m_step == 1 && !bus_wdata[16] && bus_wdata[15:0] == m_pend) m_step = 2;
            else if (m_step == 2 && bus_wdata[16] && bus_wdata[15:0] == m_pend) begin
              m_done = 1; m_lock = m_pend; m_step = 0;
            end else if (bus_wdata[16]) begin m_step = 1; m_pend = bus_wdata[15:0]; end
            else m_step = 0;
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [3:0] a);
    case (a)
      4'd0: return m_mode;
      4'd1: return {16'h0, m_ot};
      4'd2: return m_speed;
      4'd3: return m_pull;
      4'd4: return {16'h0, m_s2};
      4'd5: return {16'h0, m_out};
      4'd8: return m_aflo;
      4'd9: return m_afhi;
      4'd10: return {15'h0, m_done, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'd1: return "R3";
      4'd4: return "R8";
      4'd5: return "R7";
      4'd8, 4'd9: return "R4";
      4'd10: return "R9";
      4'd0, 4'd2, 4'd3: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) begin
    if (started) begin
      logic [15:0] e_do, e_oe;
      vectors++;
      for (int n = 0; n < 16; n++) begin
        logic dv, vv;
        dv = 0; vv = 0;
        if (m_mode[2*n +: 2] == 2'd1) begin dv = 1; vv = m_out[n]; end
        else if (m_mode[2*n +: 2] == 2'd2) begin dv = 1; vv = alt_do[n]; end
        e_do[n] = vv;
        e_oe[n] = dv && !(m_ot[n] && vv);
      end
      chk("R2 pad_mode",  64'(pad_mode),  64'(m_mode));
      chk("R2 pad_speed", 64'(pad_speed), 64'(m_speed));
      chk("R2 pad_pull",  64'(pad_pull),  64'(m_pull));
      chk("R4 pad_af_sel", pad_af_sel, {m_afhi, m_aflo});
      chk("R3 pad_do", 64'(pad_do), 64'(e_do));
      chk("R3 pad_oe", 64'(pad_oe), 64'(e_oe));
      chk({rd_tag(bus_addr), " bus_rdata"}, 64'(bus_rdata), 64'(exp_rdata(bus_addr)));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); #2;
    bus_wr_en = 1'b0;
  endtask

  task automatic look(input logic [3:0] a, input int n);
    bus_addr = a;
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic sweep();
    for (int a = 0; a < 12; a++) look(4'(a), 1);
  endtask

  task automatic all_cfg(input logic [31:0] d);
    wr(4'd0, d); wr(4'd1, d); wr(4'd2, d); wr(4'd3, d); wr(4'd8, d); wr(4'd9, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    look(4'd0, 3);
    rst_n = 1'b1;
  endtask

  initial begin
    @(posedge clk); #2;
    started = 1;
    do_reset();
    // R1: reset state of every word and pad
    sweep();

    // R2, R3, R4: configuration patterns
    wr(4'd0, 32'hE4E4_1B1B);
    wr(4'd3, 32'h5A5A_A5A5);
    wr(4'd2, 32'h0F0F_3C3C);
    wr(4'd1, 32'h0000_F00F);
    wr(4'd8, 32'h7654_3210);
    wr(4'd9, 32'hFEDC_BA98);
    alt_do = 16'hA5C3;
    sweep();
    alt_do = 16'h5A3C;
    look(4'd0, 2);

    // R7: direct write and toggle by inversion
    wr(4'd0, 32'h5555_5555);
    wr(4'd5, 32'h0000_1234);
    look(4'd5, 2);
    wr(4'd5, 32'h0000_EDCB);
    look(4'd5, 2);
    // R5: set/clear word, set wins on a shared bit
    wr(4'd6, 32'h00F0_000F);
    look(4'd5, 1);
    wr(4'd6, 32'h0008_0008);
    look(4'd5, 1);
    wr(4'd6, 32'hFFFF_0000);
    look(4'd5, 1);
    wr(4'd5, 32'h0000_FFFF);
    // R6: clear-only word
    wr(4'd7, 32'hFFFF_0030);
    look(4'd5, 2);
    wr(4'd7, 32'h0000_0000);
    look(4'd5, 1);

    // R8: input synchronizer depth
    pad_in = 16'hBEEF;
    look(4'd4, 3);
    pad_in = 16'h1234;
    look(4'd4, 1);
    pad_in = 16'h8001;
    look(4'd4, 3);

    // R10: wrong mask aborts
    wr(4'd10, 32'h0001_00F0); wr(4'd10, 32'h0000_00F1); wr(4'd10, 32'h0001_00F0);
    look(4'd10, 2);
    // R10: wrong key aborts, restart on a key-1 write
    wr(4'd10, 32'h0001_00F0); wr(4'd10, 32'h0001_00F0); wr(4'd10, 32'h0000_00F0);
    wr(4'd10, 32'h0000_00F0);
    look(4'd10, 2);
    all_cfg(32'h0000_0000);
    all_cfg(32'hA5A5_A5A5);
    sweep();

    // R9: correct sequence, with an unrelated write inside it
    wr(4'd10, 32'h0001_0F0F);
    wr(4'd0, 32'h1111_1111);
    wr(4'd10, 32'h0000_0F0F);
    wr(4'd10, 32'h0001_0F0F);
    look(4'd10, 2);

    // R11: locked fields hold, unlocked ones follow
    all_cfg(32'hFFFF_FFFF);
    sweep();
    all_cfg(32'h0000_0000);
    sweep();

    // R13: output data still moves on locked pins
    wr(4'd5, 32'h0000_0F0F);
    wr(4'd6, 32'h0F00_00F0);
    wr(4'd7, 32'h0000_0001);
    look(4'd5, 2);

    // R12: later lock writes ignored, reset clears
    wr(4'd10, 32'h0001_FFFF); wr(4'd10, 32'h0000_FFFF); wr(4'd10, 32'h0001_FFFF);
    wr(4'd10, 32'h0000_0000);
    look(4'd10, 2);
    wr(4'd0, 32'hFFFF_FFFF);
    look(4'd0, 1);
    do_reset();
    sweep();
    wr(4'd0, 32'hFFFF_FFFF);
    look(4'd0, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule